// File: doc/BRIEF.md
# Link Filler Generator and Checker

This block keeps a byte-wide link toggling at full rate while the payload it carries moves much more slowly. The link period is `gap + 1` byte slots. The first slot of each period is a real-data slot. The remaining `gap` slots hold filler. Each filler byte is the most recently sent real byte XORed with the filler's position inside the period, counted from 1 to `gap`. A receiver that shares the same `gap` value can compute every filler byte in advance, so it checks the filler instead of throwing it away. It forwards only the real bytes and reports any filler that does not match.

The sending side takes payload through a valid/ready handshake. `pay_ready` is high only during a real-data slot. If no payload is offered in that slot, the sender sends the previous real byte again with `tx_vld` low. The receiving side counts slots in lock step with the sender. It delivers each valid real byte on a one-cycle `out_valid` pulse. A mismatch sets a sticky flag and adds one to a saturating 16-bit counter, and `err_clr` clears both. Setting `gap` to 0 selects fast mode, in which every slot is a real-data slot.

A single `run` input starts both ends, so real slots line up on the same cycle everywhere. The receiver sees `run` one cycle late, which matches the one register on the link. Both ends use the state machine `SLOT_IDLE` → `SLOT_DATA` → `SLOT_FILL`, with these transitions:
- **start**: from IDLE to DATA when running.
- **open**: from DATA to FILL when `gap > 0`.
- **repeat**: from DATA to DATA in fast mode.
- **wrap**: from FILL to DATA when the position equals `gap`.
- **step**: from FILL to FILL otherwise.
- **halt**: to IDLE from any state when `run` drops.

`gap` is written through `cfg_we`. A write takes effect only while both ends are in IDLE.

Top module: `link_filler_top`

## Requirements
- R1: After reset, `tx_byte`=0, `tx_vld`=0, `pay_ready`=0, `out_valid`=0, `err_flag`=0 and `err_cnt`=0.
- R2: `run` is raised before clock edge E0, and cycles are counted from m=0 after E0. Then `pay_ready` is 1 exactly when m mod (gap+1) = 0. A payload byte accepted in such a cycle appears on `tx_byte` one cycle later with `tx_vld`=1.
- R3: A byte sent k slots after a real slot (1 ≤ k ≤ gap) equals the last real byte sent, XORed with k zero-extended to 8 bits, and has `tx_vld`=0.
- R4: In a real slot with no payload offered, `tx_byte` repeats the last real byte and `tx_vld` is 0. After reset the last real byte is 0.
- R5: With gap=0, `pay_ready` stays 1 and every link byte is a real slot.
- R6: A link byte received with `rx_vld`=1 in a real slot appears on `out_data` with `out_valid`=1 one cycle later. Filler slots and invalid real slots produce no `out_valid`.
- R7: Each filler byte that differs from the expected value sets `err_flag` one cycle later and adds one to `err_cnt`. Correct filler bytes leave both unchanged.
- R8: `err_cnt` saturates at 0xFFFF.
- R9: `err_clr` sets both `err_cnt` and `err_flag` to 0 on the next cycle, even when a mismatch arrives in the same cycle.
- R10: A `cfg_we` write made while the block is running is ignored. The slot period keeps the previously loaded gap.
- R11: Real-slot bytes are not checked. A corrupted valid real byte is delivered as received, and `err_cnt` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Starts and stops slot sequencing at both ends |
| cfg_we | input | 1 | Write strobe for the gap value; accepted only while idle |
| cfg_gap | input | GW | Number of filler slots between real slots |
| pay_valid | input | 1 | A payload byte is offered |
| pay_data | input | DW | Payload byte |
| pay_ready | output | 1 | High during a real-data slot |
| tx_byte | output | DW | Byte sent on the link |
| tx_vld | output | 1 | Sideband bit: link byte is valid real data |
| rx_byte | input | DW | Byte received from the link |
| rx_vld | input | 1 | Sideband valid bit received from the link |
| out_valid | output | 1 | Pulse: a real byte is delivered |
| out_data | output | DW | Delivered real byte |
| err_clr | input | 1 | Clears the error flag and the error counter |
| err_flag | output | 1 | Sticky filler mismatch flag |
| err_cnt | output | CW | Saturating filler mismatch count |

## Verification
The assertions assume that `err_clr` and `run` are driven synchronously. They also assume that the receive side of the link is the transmit side delayed by exactly one register, so both slot counters agree. The stimulus connects the link output back to the link input. The only change it makes on that path is an XOR mask applied on chosen cycles. It writes `gap` only after both ends have returned to IDLE, except for the deliberate mid-run write that is meant to be ignored.

// File: rtl/lf_pkg.sv
package lf_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_FILL = 2'd2
    } slot_state_e;
endpackage

// File: rtl/lf_cfg.sv
module lf_cfg #(
    parameter int GW      = 8,
    parameter int DEF_GAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [GW-1:0] gap_in,
    input  logic          idle,
    output logic [GW-1:0] gap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap <= GW'(DEF_GAP);
        else if (we && idle)
            gap <= gap_in;
    end

    AST_GAP_FROZEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(gap)); // R10
endmodule

// File: rtl/lf_tx.sv
module lf_tx
    import lf_pkg::*;
#(
    parameter int DW = 8,
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [GW-1:0] gap,
    input  logic          pay_valid,
    input  logic [DW-1:0] pay_data,
    output logic          pay_ready,
    output logic [DW-1:0] link_data,
    output logic          link_vld,
    output logic          idle
);
    slot_state_e   state, nstate;
    logic [GW-1:0] pos, npos;
    logic [DW-1:0] last_q;

    always_comb begin
        nstate = state;
        npos   = pos;
        unique case (state)
            SLOT_IDLE: begin
                if (run) begin
                    nstate = SLOT_DATA;
                    npos   = '0;
                end
            end
            SLOT_DATA: begin
                if (!run) begin
                    nstate = SLOT_IDLE;
                    npos   = '0;
                end else if (gap == '0) begin
                    nstate = SLOT_DATA;
                    npos   = '0;
                end else begin
                    nstate = SLOT_FILL;
                    npos   = GW'(1);
                end
            end
            SLOT_FILL: begin
                if (!run) begin
                    nstate = SLOT_IDLE;
                    npos   = '0;
                end else if (pos == gap) begin
                    nstate = SLOT_DATA;
                    npos   = '0;
                end else begin
                    npos = pos + GW'(1);
                end
            end
            default: begin
                nstate = SLOT_IDLE;
                npos   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SLOT_IDLE;
            pos   <= '0;
        end else begin
            state <= nstate;
            pos   <= npos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_data <= '0;
            link_vld  <= 1'b0;
            last_q    <= '0;
        end else begin
            unique case (state)
                SLOT_DATA: begin
                    if (pay_valid) begin
                        link_data <= pay_data;
                        link_vld  <= 1'b1;
                        last_q    <= pay_data;
                    end else begin
                        link_data <= last_q;
                        link_vld  <= 1'b0;
                    end
                end
                SLOT_FILL: begin
                    link_data <= last_q ^ DW'(pos);
                    link_vld  <= 1'b0;
                end
                default: begin
                    link_data <= '0;
                    link_vld  <= 1'b0;
                end
            endcase
        end
    end

    assign pay_ready = (state == SLOT_DATA);
    assign idle      = (state == SLOT_IDLE);

    AST_FILL_NEVER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SLOT_DATA) |=> !link_vld); // R3
    AST_POS_WITHIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SLOT_IDLE) |-> (pos <= gap)); // R2
    AST_FAST_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (gap == '0 && $past(gap) == '0 && state != SLOT_IDLE) |-> (state == SLOT_DATA)); // R5
endmodule

// File: rtl/lf_rx.sv
module lf_rx
    import lf_pkg::*;
#(
    parameter int DW = 8,
    parameter int GW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [GW-1:0] gap,
    input  logic [DW-1:0] link_data,
    input  logic          link_vld,
    input  logic          clr,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          err_flag,
    output logic [CW-1:0] err_cnt,
    output logic          idle
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    slot_state_e   state, nstate;
    logic [GW-1:0] pos, npos;
    logic [DW-1:0] last_q;
    logic          mismatch;

    always_comb begin
        nstate = state;
        npos   = pos;
        unique case (state)
            SLOT_IDLE: begin
                if (run) begin
                    nstate = SLOT_DATA;
                    npos   = '0;
                end
            end
            SLOT_DATA: begin
                if (!run) begin
                    nstate = SLOT_IDLE;
                    npos   = '0;
                end else if (gap == '0) begin
                    nstate = SLOT_DATA;
                    npos   = '0;
                end else begin
                    nstate = SLOT_FILL;
                    npos   = GW'(1);
                end
            end
            SLOT_FILL: begin
                if (!run) begin
                    nstate = SLOT_IDLE;
                    npos   = '0;
                end else if (pos == gap) begin
                    nstate = SLOT_DATA;
                    npos   = '0;
                end else begin
                    npos = pos + GW'(1);
                end
            end
            default: begin
                nstate = SLOT_IDLE;
                npos   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SLOT_IDLE;
            pos   <= '0;
        end else begin
            state <= nstate;
            pos   <= npos;
        end
    end

    assign mismatch = (state == SLOT_FILL) && (link_data != (last_q ^ DW'(pos)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            last_q    <= '0;
        end else begin
            out_valid <= 1'b0;
            if (state == SLOT_DATA && link_vld) begin
                out_valid <= 1'b1;
                out_data  <= link_data;
                last_q    <= link_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_cnt  <= '0;
        end else if (clr) begin
            err_flag <= 1'b0;
            err_cnt  <= '0;
        end else if (mismatch) begin
            err_flag <= 1'b1;
            if (err_cnt != CNT_MAX)
                err_cnt <= err_cnt + CW'(1);
        end
    end

    assign idle = (state == SLOT_IDLE);

    AST_OUT_FROM_DATA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state == SLOT_DATA)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == CNT_MAX && !clr) |=> (err_cnt == CNT_MAX)); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_cnt == '0 && !err_flag)); // R9
endmodule

// File: rtl/link_filler_top.sv
module link_filler_top #(
    parameter int DW      = 8,
    parameter int GW      = 8,
    parameter int CW      = 16,
    parameter int DEF_GAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cfg_we,
    input  logic [GW-1:0] cfg_gap,
    input  logic          pay_valid,
    input  logic [DW-1:0] pay_data,
    output logic          pay_ready,
    output logic [DW-1:0] tx_byte,
    output logic          tx_vld,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_vld,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          err_clr,
    output logic          err_flag,
    output logic [CW-1:0] err_cnt
);
    logic [GW-1:0] gap;
    logic          tx_idle, rx_idle, run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    lf_cfg #(.GW(GW), .DEF_GAP(DEF_GAP)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .gap_in(cfg_gap),
        .idle(tx_idle && rx_idle), .gap(gap)
    );

    lf_tx #(.DW(DW), .GW(GW)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(run), .gap(gap),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
        .link_data(tx_byte), .link_vld(tx_vld), .idle(tx_idle)
    );

    lf_rx #(.DW(DW), .GW(GW), .CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(run_q), .gap(gap),
        .link_data(rx_byte), .link_vld(rx_vld), .clr(err_clr),
        .out_valid(out_valid), .out_data(out_data),
        .err_flag(err_flag), .err_cnt(err_cnt), .idle(rx_idle)
    );
endmodule

// File: tb/tb_link_filler_top.sv
module tb_link_filler_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_gap = '0;
    logic       pay_valid = 1'b0;
    logic [7:0] pay_data = '0;
    logic       pay_ready;
    logic [7:0] tx_byte;
    logic       tx_vld;
    logic [7:0] inj = '0;
    logic [7:0] rx_byte;
    logic       out_valid;
    logic [7:0] out_data;
    logic       err_clr = 1'b0;
    logic       err_flag;
    logic [15:0] err_cnt;

    int checks = 0;
    int failures = 0;
    logic [7:0] blast = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_byte = tx_byte ^ inj;

    link_filler_top dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_gap(cfg_gap),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
        .tx_byte(tx_byte), .tx_vld(tx_vld), .rx_byte(rx_byte), .rx_vld(tx_vld),
        .out_valid(out_valid), .out_data(out_data), .err_clr(err_clr),
        .err_flag(err_flag), .err_cnt(err_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_gap(input int g);
        @(negedge clk);
        cfg_gap = 8'(g);
        cfg_we  = 1'b1;
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    // One running sequence with bench model; bad1/bad2 corrupt a filler, bad_real a real slot.
    task automatic run_seq(input int g, input int len, input int bad1, input int bad2, input int bad_real);
        logic [7:0] exp_b = '0;
        logic       exp_v = 1'b0;
        logic [7:0] prv_b = '0;
        logic       prv_v = 1'b0;
        int         exp_err = 0;
        bit         pv;
        logic [7:0] pd;
        string      tag;
        set_gap(g);
        @(negedge clk);
        run = 1'b1;
        for (int m = 0; m < len; m++) begin
            @(posedge clk);
            @(negedge clk);
            inj = '0;
            if (g == 0) tag = "R5";
            else if (m >= 1 && ((m-1) % (g+1)) != 0) tag = "R3";
            else if (exp_v) tag = "R2";
            else tag = "R4";
            chk(tx_vld == exp_v, tag, int'(tx_vld), int'(exp_v));
            chk(tx_byte == exp_b, tag, int'(tx_byte), int'(exp_b));
            chk(out_valid == prv_v, (m == bad_real + 1) ? "R11" : "R6", int'(out_valid), int'(prv_v));
            if (prv_v)
                chk(out_data == prv_b, (m == bad_real + 1) ? "R11" : "R6", int'(out_data), int'(prv_b));
            chk(pay_ready == ((m % (g+1)) == 0), (m > 5) ? "R10" : ((g == 0) ? "R5" : "R2"),
                int'(pay_ready), int'((m % (g+1)) == 0));
            chk(err_cnt == 16'(exp_err), (m == bad_real + 1) ? "R11" : "R7", int'(err_cnt), exp_err);
            chk(err_flag == (exp_err != 0), "R7", int'(err_flag), int'(exp_err != 0));
            prv_v = exp_v;
            prv_b = exp_b;
            if (m == bad1 || m == bad2) begin
                inj = 8'h5A;
                exp_err++;
            end else if (m == bad_real) begin
                inj = 8'h3C;
                prv_b = prv_b ^ 8'h3C;
            end
            // R10: mid-run write of another gap must be ignored
            if (m == 5) begin
                cfg_gap = 8'(g + 3);
                cfg_we  = 1'b1;
            end else begin
                cfg_we  = 1'b0;
            end
            pv = ((m / (g+1)) % 3) != 1;
            pd = 8'((m * 37 + g * 5 + 1) & 255);
            pay_valid = pv;
            pay_data  = pd;
            if ((m % (g+1)) == 0) begin
                if (pv) begin
                    exp_b = pd;
                    exp_v = 1'b1;
                    blast = pd;
                end else begin
                    exp_b = blast;
                    exp_v = 1'b0;
                end
            end else begin
                exp_b = blast ^ 8'(m % (g+1));
                exp_v = 1'b0;
            end
        end
        @(negedge clk);
        inj = '0;
        run = 1'b0;
        pay_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int guard;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_byte == 8'h00 && tx_vld == 1'b0, "R1", int'(tx_byte), 0);
        chk(pay_ready == 1'b0, "R1", int'(pay_ready), 0);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(err_flag == 1'b0 && err_cnt == 16'h0, "R1", int'(err_cnt), 0);

        // Sweep of all small gap values, including fast mode (R5)
        for (int g = 0; g < 8; g++)
            run_seq(g, 6 * (g + 1) + 8, -1, -1, -1);

        // Filler corruption (R7) and real-slot corruption (R11)
        run_seq(3, 23, 7, 14, 21);

        // Fresh start for the saturation test
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        blast = '0;
        set_gap(7);
        @(negedge clk);
        run = 1'b1;
        @(posedge clk); @(negedge clk);           // m=0
        @(posedge clk); @(negedge clk);           // m=1: real slot, no payload
        chk(tx_byte == 8'h00 && tx_vld == 1'b0, "R4", int'(tx_byte), 0);
        @(posedge clk); @(negedge clk);           // m=2: first filler
        chk(tx_byte == 8'h01, "R3", int'(tx_byte), 1);
        inj = 8'hFF;
        guard = 0;
        while (err_cnt != 16'hFFFF && guard < 80000) begin
            @(negedge clk);
            guard++;
        end
        chk(err_cnt == 16'hFFFF, "R8", int'(err_cnt), 16'hFFFF);
        repeat (30) @(negedge clk);
        chk(err_cnt == 16'hFFFF, "R8", int'(err_cnt), 16'hFFFF);
        chk(err_flag == 1'b1, "R7", int'(err_flag), 1);
        err_clr = 1'b1;                            // mismatches still arriving
        @(negedge clk);
        chk(err_cnt == 16'h0, "R9", int'(err_cnt), 0);
        chk(err_flag == 1'b0, "R9", int'(err_flag), 0);
        inj = 8'h00;
        @(negedge clk);
        err_clr = 1'b0;
        repeat (20) @(negedge clk);
        chk(err_cnt == 16'h0 && err_flag == 1'b0, "R9", int'(err_cnt), 0);
        run = 1'b0;
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule